// File: doc/BRIEF.md
# Parallel Write-Back Merge with Flag Arbitration

This block holds the register writes that a wide instruction word produces while it executes. When the word retires, it commits all of those writes in a single cycle. It holds a short queue of 32-bit writes. Each write names a target (a general register or the status word), a bit mask and a value. A second short queue holds full 64-bit accumulator writes. On the commit strobe, every queued write is applied in the order it was queued. The general registers, the status word and the accumulators are updated together, and both queues are emptied.

Two execution units may update status flags in the same word. When they do, the status-word writes are arbitrated flag by flag, and a later status write wins every contested flag. An overflow update in the later write also shields the accumulated-overflow flag from the earlier write. Arbitration is switched off when the left slot of the word was a move into a system register. A one-cycle pulse reports that the status word was written, so that the surrounding logic can re-check the stack bank. A second one-cycle pulse reports a write that was dropped because its queue was full.

Top module: `wb_merge`

## Requirements
- R1: After reset, every general register, the status word and every accumulator read zero, and `psw_wr` and `ovf_err` are low.
- R2: A committed 32-bit write leaves the target at (old & ~mask) | (value & mask). Bits outside the mask keep their previous value.
- R3: Queued 32-bit writes are applied in queue order, so a later write to the same target overrides an earlier one on the bits they share.
- R4: Target index NREG (8 by default) selects the status word, and indices 0..NREG-1 select general registers. The contested flags sit at bits 0..7: F0=0, F1=1, F2=2, F3=3, S=4, V=5, VA=6, C=7. In a status write, every flag bit that a later status write in the same commit also masks is removed from the earlier write's mask. Bits 8..31 are never arbitrated.
- R5: If a later status write in the same commit masks V (bit 5), the earlier status write's VA bit (bit 6) is also removed from its mask. As a result, VA keeps the value it had before the commit.
- R6: When `left_sysmove` is high in the commit cycle, the arbitration of R4 and R5 is skipped, and the earlier status write applies its full mask.
- R7: Committed accumulator writes store all 64 bits, unmasked, in queue order, after the 32-bit writes.
- R8: Until a commit occurs, queued writes leave the registers, the status word and the accumulators unchanged.
- R9: `psw_wr` is high in the cycle after a commit whose queue held at least one status-word write, and low otherwise.
- R10: The 32-bit queue holds 4 entries and the 64-bit queue holds 2. A push into a full queue without commit is dropped, and `ovf_err` is high for the following cycle.
- R11: A commit empties both queues, and a push presented in the commit cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push32 | input | 1 | Queue a 32-bit write |
| p32_idx | input | $clog2(NREG+1) | Target index (NREG = status word) |
| p32_mask | input | 32 | Bit mask of the write |
| p32_val | input | 32 | Value of the write |
| push64 | input | 1 | Queue an accumulator write |
| p64_idx | input | $clog2(NACC) | Accumulator index |
| p64_val | input | 64 | Accumulator value |
| commit | input | 1 | Commit all queued writes |
| left_sysmove | input | 1 | Left slot was a system-register move; disables flag arbitration |
| regs | output | NREG*32 | General registers, register r at bits r*32 upward |
| psw | output | 32 | Status word |
| accs | output | NACC*64 | Accumulators, accumulator a at bits a*64 upward |
| psw_wr | output | 1 | Status word written by the last commit |
| ovf_err | output | 1 | A push was dropped on a full queue |

## Verification
The bench uses the default parameters: 8 general registers, a 4-deep 32-bit queue, a 2-deep accumulator queue and 2 accumulators. With these values the status-word index is 8, so a 4-bit target field that also reaches into unused codes. A fifth 32-bit push or a third accumulator push reaches the dropped-entry path. A full queue can hold two status writes next to general-register writes, so arbitration is exercised with the system-move flag both low and high. This includes the case where an overflow update in the later write shields an earlier accumulated-overflow write.

// File: rtl/wb_merge.sv
module wb_merge #(
  parameter int NREG = 8,
  parameter int Q32  = 4,
  parameter int Q64  = 2,
  parameter int NACC = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push32,
  input  logic [$clog2(NREG+1)-1:0]     p32_idx,
  input  logic [31:0]                   p32_mask,
  input  logic [31:0]                   p32_val,
  input  logic                          push64,
  input  logic [$clog2(NACC)-1:0]       p64_idx,
  input  logic [63:0]                   p64_val,
  input  logic                          commit,
  input  logic                          left_sysmove,
  output logic [NREG*32-1:0]            regs,
  output logic [31:0]                   psw,
  output logic [NACC*64-1:0]            accs,
  output logic                          psw_wr,
  output logic                          ovf_err
);
  localparam int TW   = $clog2(NREG+1);
  localparam int AW   = $clog2(NACC);
  localparam int CW32 = $clog2(Q32+1);
  localparam int CW64 = $clog2(Q64+1);
  localparam logic [TW-1:0] PSW_IDX = TW'(NREG);
  localparam logic [31:0] FLAGS = 32'h0000_00FF;
  localparam logic [31:0] VBIT  = 32'h0000_0020;
  localparam logic [31:0] VABIT = 32'h0000_0040;

  logic [TW-1:0]   q_idx  [Q32];
  logic [31:0]     q_mask [Q32];
  logic [31:0]     q_val  [Q32];
  logic [CW32-1:0] q_cnt;
  logic [AW-1:0]   a_idx  [Q64];
  logic [63:0]     a_val  [Q64];
  logic [CW64-1:0] a_cnt;

  logic [31:0] rf    [NREG];
  logic [31:0] rf_n  [NREG];
  logic [63:0] acc   [NACC];
  logic [63:0] acc_n [NACC];
  logic [31:0] psw_q, psw_n;
  logic        hit;

  wire full32 = (q_cnt == CW32'(Q32));
  wire full64 = (a_cnt == CW64'(Q64));
  wire take32 = push32 && !commit && !full32;
  wire take64 = push64 && !commit && !full64;

  always_ff @(posedge clk) begin
    for (int e = 0; e < Q32; e++)
      if (take32 && q_cnt == CW32'(e)) begin
        q_idx[e]  <= p32_idx;
        q_mask[e] <= p32_mask;
        q_val[e]  <= p32_val;
      end
    for (int e = 0; e < Q64; e++)
      if (take64 && a_cnt == CW64'(e)) begin
        a_idx[e] <= p64_idx;
        a_val[e] <= p64_val;
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_cnt   <= '0;
      a_cnt   <= '0;
      ovf_err <= 1'b0;
    end else begin
      ovf_err <= !commit && ((push32 && full32) || (push64 && full64));
      if (commit) begin
        q_cnt <= '0;
        a_cnt <= '0;
      end else begin
        if (take32) q_cnt <= q_cnt + 1'b1;
        if (take64) a_cnt <= a_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    rf_n  = rf;
    acc_n = acc;
    psw_n = psw_q;
    hit   = 1'b0;
    for (int i = 0; i < Q32; i++) begin
      logic [31:0] eff;
      eff = q_mask[i];
      if (CW32'(i) < q_cnt) begin
        if (q_idx[i] == PSW_IDX) begin
          if (!left_sysmove)
            for (int j = i + 1; j < Q32; j++)
              if (CW32'(j) < q_cnt && q_idx[j] == PSW_IDX) begin
                eff = eff & ~(q_mask[j] & FLAGS);
                if ((q_mask[j] & VBIT) != '0) eff = eff & ~VABIT;
              end
          psw_n = (psw_n & ~eff) | (q_val[i] & eff);
          hit   = 1'b1;
        end else begin
          for (int r = 0; r < NREG; r++)
            if (q_idx[i] == TW'(r))
              rf_n[r] = (rf_n[r] & ~eff) | (q_val[i] & eff);
        end
      end
    end
    for (int i = 0; i < Q64; i++)
      if (CW64'(i) < a_cnt)
        for (int a = 0; a < NACC; a++)
          if (a_idx[i] == AW'(a)) acc_n[a] = a_val[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) rf[r] <= '0;
      for (int a = 0; a < NACC; a++) acc[a] <= '0;
      psw_q  <= '0;
      psw_wr <= 1'b0;
    end else begin
      psw_wr <= commit && hit;
      if (commit) begin
        rf    <= rf_n;
        acc   <= acc_n;
        psw_q <= psw_n;
      end
    end
  end

  assign psw = psw_q;
  for (genvar r = 0; r < NREG; r++) begin : g_rf
    assign regs[r*32 +: 32] = rf[r];
  end
  for (genvar a = 0; a < NACC; a++) begin : g_acc
    assign accs[a*64 +: 64] = acc[a];
  end
endmodule

// File: rtl/wb_merge_chk.sv
module wb_merge_chk #(
  parameter int Q32  = 4,
  parameter int Q64  = 2,
  parameter int CW32 = 3,
  parameter int CW64 = 2,
  parameter int RW   = 256,
  parameter int AWID = 128
) (
  input logic            clk,
  input logic            rst_n,
  input logic            push32,
  input logic            push64,
  input logic            commit,
  input logic [CW32-1:0] q_cnt,
  input logic [CW64-1:0] a_cnt,
  input logic            psw_wr,
  input logic            ovf_err,
  input logic [31:0]     psw,
  input logic [RW-1:0]   regs,
  input logic [AWID-1:0] accs
);
  a_r11_commit_empties: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (q_cnt == '0 && a_cnt == '0));

  a_r10_ovf_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && ((push32 && q_cnt == CW32'(Q32)) || (push64 && a_cnt == CW64'(Q64)))) |=> ovf_err);

  a_r10_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |-> $past(!commit && (push32 || push64)));

  a_r10_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt <= CW32'(Q32)) && (a_cnt <= CW64'(Q64)));

  a_r8_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(psw) && $stable(regs) && $stable(accs)));

  a_r9_psw_wr_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    psw_wr |-> $past(commit));
endmodule

bind wb_merge wb_merge_chk #(
  .Q32(Q32), .Q64(Q64), .CW32(CW32), .CW64(CW64), .RW(NREG*32), .AWID(NACC*64)
) u_chk (
  .clk(clk), .rst_n(rst_n), .push32(push32), .push64(push64), .commit(commit),
  .q_cnt(q_cnt), .a_cnt(a_cnt), .psw_wr(psw_wr), .ovf_err(ovf_err),
  .psw(psw), .regs(regs), .accs(accs)
);

// File: tb/sim_wb_merge.sv
module sim_wb_merge;
  localparam int NREG = 8, Q32 = 4, Q64 = 2, NACC = 2;
  localparam int TW = $clog2(NREG+1), AW = $clog2(NACC);

  typedef struct packed {
    logic [NREG*32-1:0] r;
    logic [31:0]        p;
    logic [NACC*64-1:0] a;
    logic               pw;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic push32 = 0, push64 = 0, commit = 0, left_sysmove = 0;
  logic [TW-1:0] p32_idx = '0;
  logic [31:0] p32_mask = '0, p32_val = '0;
  logic [AW-1:0] p64_idx = '0;
  logic [63:0] p64_val = '0;
  logic [NREG*32-1:0] regs;
  logic [31:0] psw;
  logic [NACC*64-1:0] accs;
  logic psw_wr, ovf_err;

  int errors = 0, checks = 0;
  logic cmt_d = 0;
  exp_t sbq[$];

  logic [31:0] m_rf [NREG];
  logic [31:0] m_psw;
  logic [63:0] m_acc [NACC];
  int          pq_idx[$];
  logic [31:0] pq_mask[$], pq_val[$];
  int          pa_idx[$];
  logic [63:0] pa_val[$];

  always #5 clk = ~clk;

  wb_merge #(.NREG(NREG), .Q32(Q32), .Q64(Q64), .NACC(NACC)) u0 (
    .clk(clk), .rst_n(rst_n), .push32(push32), .p32_idx(p32_idx), .p32_mask(p32_mask),
    .p32_val(p32_val), .push64(push64), .p64_idx(p64_idx), .p64_val(p64_val),
    .commit(commit), .left_sysmove(left_sysmove), .regs(regs), .psw(psw), .accs(accs),
    .psw_wr(psw_wr), .ovf_err(ovf_err));

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t model_flat(input bit pw);
    exp_t e;
    for (int r = 0; r < NREG; r++) e.r[r*32 +: 32] = m_rf[r];
    for (int a = 0; a < NACC; a++) e.a[a*64 +: 64] = m_acc[a];
    e.p = m_psw;
    e.pw = pw;
    return e;
  endfunction

  task automatic push_w(input int idx, input logic [31:0] mask, input logic [31:0] val);
    bit full = (pq_idx.size() == Q32);
    if (!full) begin pq_idx.push_back(idx); pq_mask.push_back(mask); pq_val.push_back(val); end
    p32_idx = TW'(idx); p32_mask = mask; p32_val = val; push32 = 1;
    @(negedge clk);
    push32 = 0;
    check(ovf_err == full, "R10 ovf_err after 32-bit push", 256'(ovf_err), 256'(full));
  endtask

  task automatic push_a(input int idx, input logic [63:0] val);
    bit full = (pa_idx.size() == Q64);
    if (!full) begin pa_idx.push_back(idx); pa_val.push_back(val); end
    p64_idx = AW'(idx); p64_val = val; push64 = 1;
    @(negedge clk);
    push64 = 0;
    check(ovf_err == full, "R10 ovf_err after accumulator push", 256'(ovf_err), 256'(full));
  endtask

  // R2..R7, R9, R11: expected result computed from the requirements
  task automatic do_commit(input bit sysmove, input bit stray_push);
    bit pw = 0;
    for (int i = 0; i < pq_idx.size(); i++) begin
      logic [31:0] eff = pq_mask[i];
      if (pq_idx[i] == NREG) begin
        pw = 1;
        if (!sysmove)
          for (int j = i + 1; j < pq_idx.size(); j++)
            if (pq_idx[j] == NREG) begin
              eff &= ~(pq_mask[j] & 32'hFF);
              if (pq_mask[j][5]) eff &= ~32'h40;
            end
        m_psw = (m_psw & ~eff) | (pq_val[i] & eff);
      end else if (pq_idx[i] < NREG)
        m_rf[pq_idx[i]] = (m_rf[pq_idx[i]] & ~eff) | (pq_val[i] & eff);
    end
    for (int i = 0; i < pa_idx.size(); i++) m_acc[pa_idx[i]] = pa_val[i];
    sbq.push_back(model_flat(pw));
    pq_idx.delete(); pq_mask.delete(); pq_val.delete(); pa_idx.delete(); pa_val.delete();
    commit = 1; left_sysmove = sysmove;
    if (stray_push) begin
      push32 = 1; p32_idx = TW'(6); p32_mask = 32'hFFFF_FFFF; p32_val = 32'hDEAD_BEEF;
    end
    @(negedge clk);
    commit = 0; left_sysmove = 0; push32 = 0;
    @(negedge clk);
  endtask

  always @(posedge clk) cmt_d <= commit;

  always @(negedge clk) begin
    if (cmt_d) begin
      exp_t e;
      e = sbq.pop_front();
      check(regs == e.r, "R2/R3 registers after commit", 256'(regs), 256'(e.r));
      check(psw == e.p, "R4/R5/R6 status word after commit", 256'(psw), 256'(e.p));
      check(accs == e.a, "R7 accumulators after commit", 256'(accs), 256'(e.a));
      check(psw_wr == e.pw, "R9 psw_wr after commit", 256'(psw_wr), 256'(e.pw));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int r = 0; r < NREG; r++) m_rf[r] = '0;
    for (int a = 0; a < NACC; a++) m_acc[a] = '0;
    m_psw = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(regs == '0, "R1 registers at reset", 256'(regs), 256'(0));
    check(psw == '0, "R1 status word at reset", 256'(psw), 256'(0));
    check(accs == '0, "R1 accumulators at reset", 256'(accs), 256'(0));
    check(!psw_wr && !ovf_err, "R1 pulses low at reset", 256'({psw_wr, ovf_err}), 256'(0));
    rst_n = 1;
    @(negedge clk);

    // R2: masked writes merge with old contents
    push_w(3, 32'h0000_FFFF, 32'h1234_5678);
    push_w(5, 32'hFFFF_FFFF, 32'hAABB_CCDD);
    do_commit(0, 0);
    push_w(3, 32'hFF00_0000, 32'h9AFF_FFFF);
    do_commit(0, 0);

    // R3 and R8: queue order, no change before commit
    push_w(2, 32'hFFFF_FFFF, 32'h1);
    push_w(2, 32'hFFFF_FFFF, 32'h2);
    push_w(2, 32'h0000_00F0, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    check(regs[2*32 +: 32] == 32'h0, "R8 register unchanged before commit", 256'(regs[2*32 +: 32]), 256'(0));
    do_commit(0, 0);
    check(regs[2*32 +: 32] == 32'hF2, "R3 later write wins", 256'(regs[2*32 +: 32]), 256'(32'hF2));

    // R4: two status writes, later wins contested flags, upper bits untouched by arbitration
    push_w(8, 32'h0010_000F, 32'h0010_000F);
    push_w(1, 32'hFFFF_FFFF, 32'h0000_0011);
    push_w(8, 32'h0000_0001, 32'h0);
    do_commit(0, 0);
    check(psw == 32'h0010_000E, "R4 contested flag arbitration", 256'(psw), 256'(32'h0010_000E));

    // R5: later V update shields earlier VA
    push_w(8, 32'h0000_0040, 32'h0000_0040);
    push_w(8, 32'h0000_0020, 32'h0000_0020);
    do_commit(0, 0);
    check(psw[6] == 1'b0, "R5 VA suppressed by later V", 256'(psw[6]), 256'(0));

    // R6: system move disables arbitration
    push_w(8, 32'hFFFF_FFFF, 32'h0);
    do_commit(0, 0);
    push_w(8, 32'h0000_0040, 32'h0000_0040);
    push_w(8, 32'h0000_0020, 32'h0000_0020);
    do_commit(1, 0);
    check(psw[6] == 1'b1, "R6 VA kept under system move", 256'(psw[6]), 256'(1));

    // R7 and R10: accumulator order and third push dropped
    push_a(0, 64'h1111_2222_3333_4444);
    push_a(0, 64'h5555_6666_7777_8888);
    push_a(1, 64'hFFFF_FFFF_FFFF_FFFF);
    do_commit(0, 0);
    push_a(1, 64'h0123_4567_89AB_CDEF);
    do_commit(0, 0);

    // R10: fifth 32-bit push dropped
    for (int k = 0; k < 4; k++) push_w(k, 32'hFFFF_FFFF, 32'hA0 + k);
    push_w(7, 32'hFFFF_FFFF, 32'h77);
    do_commit(0, 0);
    check(regs[7*32 +: 32] == 32'h0, "R10 dropped write not applied", 256'(regs[7*32 +: 32]), 256'(0));

    // R11: queue cleared, four more pushes fit; push during commit ignored
    for (int k = 0; k < 4; k++) push_w(4 + k, 32'h0000_FFFF, 32'hB0 + k);
    do_commit(0, 1);
    do_commit(0, 0);
    check(regs[6*32 +: 32] == 32'hB2, "R11 push in commit cycle ignored", 256'(regs[6*32 +: 32]), 256'(32'hB2));

    repeat (2) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule